// File: doc/BRIEF.md
# Accumulator Instruction Core

This block is a small 16-bit processor built around one working register, the accumulator. It steps through a program held in a byte-wide instruction memory. Every instruction is exactly three bytes long: an opcode byte followed by a 16-bit data address. The core reads and writes a 16-bit data memory. Arithmetic always takes the accumulator as one operand and writes the result back into it.

Both memory ports read combinationally: the data for an address arrives in the same cycle. Each instruction takes four clock cycles, one for each fetched byte and one to execute. A halt opcode stops the core until the next reset. The program counter and the accumulator are brought out for observation. Two counters track memory traffic, one for instruction bytes fetched and one for data bytes moved, so that code size and data traffic can be measured for a program.

Top module: `acc_core`

## Requirements
- R1: While reset is held low, and at its release, pc = 0, acc = 0, halted = 0 and both byte counters are 0.
- R2: Each instruction is fetched as three bytes from consecutive addresses pc, pc+1 and pc+2. The first byte is the opcode, the second is the high address byte and the third is the low address byte. After a non-halt instruction, pc advances by 3.
- R3: Opcode 0x01 (load) sets acc to the data word at the 16-bit address.
- R4: Opcode 0x02 (store) writes acc to the data word at the address with exactly one write strobe, and it never reads and writes in the same cycle.
- R5: Opcode 0x03 (add) sets acc to acc plus the data word at the address, modulo 2^16, with no carry kept.
- R6: Any opcode other than 0x01, 0x02, 0x03 and 0xFF does nothing except use its three bytes. It makes no data access and leaves acc unchanged.
- R7: Opcode 0xFF (halt) raises halted and keeps pc at the address of the halt instruction. After that there is no further instruction fetch and no data access until reset.
- R8: The instruction byte counter rises by 1 for each byte fetched, including the three bytes of the halt instruction. The data byte counter rises by 2 for each load, store or add.
- R9: Each instruction takes four clock cycles. With k instructions before a halt, halted first reads 1 after 4*(k+1) rising edges past the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_re | output | 1 | Instruction byte read strobe |
| imem_addr | output | 16 | Instruction byte address |
| imem_data | input | 8 | Instruction byte, valid in the same cycle |
| dmem_re | output | 1 | Data read strobe |
| dmem_we | output | 1 | Data write strobe |
| dmem_addr | output | 16 | Data word address |
| dmem_wdata | output | 16 | Data to write |
| dmem_rdata | input | 16 | Data read, valid in the same cycle |
| pc | output | 16 | Program counter |
| acc | output | 16 | Accumulator |
| halted | output | 1 | High once a halt instruction has executed |
| ifetch_bytes | output | 32 | Instruction bytes fetched |
| data_bytes | output | 32 | Data bytes moved |

## Verification
The assertions assume that both memories answer in the same cycle. They also assume that reset is held for at least one edge before any program runs, so the counters and pc begin from zero. The bench models the memories as combinational arrays, and it reloads the program and the data only while reset is low. Every program it generates ends in a halt opcode placed well inside the instruction array. Data addresses use only the high byte values 0x00 and 0x01, so every access falls inside the modelled data array while the order of the two address bytes still changes the word that is reached.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              imem_re,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [7:0]        imem_data,
  output logic              dmem_re,
  output logic              dmem_we,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic              halted,
  output logic [CNT_W-1:0]  ifetch_bytes,
  output logic [CNT_W-1:0]  data_bytes
);
  localparam logic [7:0] OP_LD  = 8'h01;
  localparam logic [7:0] OP_ST  = 8'h02;
  localparam logic [7:0] OP_ADD = 8'h03;
  localparam logic [7:0] OP_HLT = 8'hFF;
  localparam int         HALF_W = ADDR_W / 2;
  localparam logic [ADDR_W-1:0] INSN_LEN = ADDR_W'(3);
  localparam logic [CNT_W-1:0]  WORD_BYTES = CNT_W'(DATA_W / 8);

  typedef enum logic [2:0] {S_OP, S_HI, S_LO, S_EX, S_HALT} phase_t;

  phase_t            state;
  logic [7:0]        opcode;
  logic [HALF_W-1:0] addr_hi, addr_lo;
  logic              is_mem_op;

  assign imem_re    = (state == S_OP) || (state == S_HI) || (state == S_LO);
  assign imem_addr  = pc + ((state == S_HI) ? ADDR_W'(1) :
                            (state == S_LO) ? ADDR_W'(2) : ADDR_W'(0));
  assign is_mem_op  = (opcode == OP_LD) || (opcode == OP_ST) || (opcode == OP_ADD);
  assign dmem_addr  = {addr_hi, addr_lo};
  assign dmem_wdata = acc;
  assign dmem_we    = (state == S_EX) && (opcode == OP_ST);
  assign dmem_re    = (state == S_EX) && ((opcode == OP_LD) || (opcode == OP_ADD));
  assign halted     = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_OP;
      pc           <= '0;
      acc          <= '0;
      opcode       <= '0;
      addr_hi      <= '0;
      addr_lo      <= '0;
      ifetch_bytes <= '0;
      data_bytes   <= '0;
    end else begin
      if (imem_re) ifetch_bytes <= ifetch_bytes + CNT_W'(1);
      case (state)
        S_OP: begin
          opcode <= imem_data;
          state  <= S_HI;
        end
        S_HI: begin
          addr_hi <= imem_data[HALF_W-1:0];
          state   <= S_LO;
        end
        S_LO: begin
          addr_lo <= imem_data[HALF_W-1:0];
          state   <= S_EX;
        end
        S_EX: begin
          if (opcode == OP_LD)  acc <= dmem_rdata;
          if (opcode == OP_ADD) acc <= acc + dmem_rdata;
          if (is_mem_op) data_bytes <= data_bytes + WORD_BYTES;
          if (opcode == OP_HLT) begin
            state <= S_HALT;
          end else begin
            pc    <= pc + INSN_LEN;
            state <= S_OP;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              imem_re,
  input logic              dmem_re,
  input logic              dmem_we,
  input logic [ADDR_W-1:0] pc,
  input logic              halted,
  input logic [CNT_W-1:0]  ifetch_bytes,
  input logic [CNT_W-1:0]  data_bytes
);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pc != $past(pc)) |-> (pc == $past(pc) + ADDR_W'(3)));

  assert_rw_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re) && !(imem_re && (dmem_we || dmem_re)));

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(ifetch_bytes) && $stable(data_bytes)));

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!imem_re && !dmem_re && !dmem_we));

  assert_icnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (ifetch_bytes == $past(ifetch_bytes) + CNT_W'($past(imem_re))));

  assert_dcnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (data_bytes == $past(data_bytes) +
              (($past(dmem_re) || $past(dmem_we)) ? CNT_W'(2) : CNT_W'(0))));
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_re, dmem_re, dmem_we, halted;
  logic [15:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata, pc, acc;
  logic [7:0]  imem_data;
  logic [31:0] ifetch_bytes, data_bytes;

  logic [7:0]  imem [1024];
  logic [15:0] dmem [512];
  logic [15:0] mref [512];
  logic [7:0]  p_op [64];
  logic [15:0] p_ad [64];

  int checks = 0, fails = 0, cycles = 0;
  int fetch_exp = 0, fetch_err = 0, post_halt_wr = 0;

  always #10 clk = ~clk;

  assign imem_data  = imem[imem_addr[9:0]];
  assign dmem_rdata = dmem[dmem_addr[8:0]];

  acc_core dut_i (.*);

  always @(negedge clk) begin
    if (rst_n && imem_re) begin
      if (imem_addr !== 16'(fetch_exp)) fetch_err++;
      fetch_exp++;
    end
    if (rst_n && dmem_we) begin
      if (halted) post_halt_wr++;
      dmem[dmem_addr[8:0]] = dmem_wdata;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_addr();
    return {7'b0, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255))};
  endfunction

  task automatic run_prog(input int n);
    logic [15:0] racc = '0;
    int dops = 0, cyc = 0;
    logic [15:0] pc_h;
    logic [31:0] if_h;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) imem[i] = 8'h00;
    for (int i = 0; i < n; i++) begin
      imem[3*i] = p_op[i]; imem[3*i+1] = p_ad[i][15:8]; imem[3*i+2] = p_ad[i][7:0];
    end
    imem[3*n] = 8'hFF; imem[3*n+1] = 8'($urandom); imem[3*n+2] = 8'($urandom);
    for (int i = 0; i < 512; i++) mref[i] = dmem[i];
    for (int i = 0; i < n; i++) begin
      case (p_op[i])
        8'h01: begin racc = mref[p_ad[i][8:0]]; dops++; end
        8'h02: begin mref[p_ad[i][8:0]] = racc; dops++; end
        8'h03: begin racc = racc + mref[p_ad[i][8:0]]; dops++; end
        default: ;
      endcase
    end
    repeat (3) @(negedge clk);
    chk("R1 pc", 32'(pc), 0);
    chk("R1 acc", 32'(acc), 0);
    chk("R1 halted", 32'(halted), 0);
    chk("R1 counters", ifetch_bytes | data_bytes, 0);
    fetch_exp = 0; fetch_err = 0; post_halt_wr = 0;
    rst_n = 1'b1;
    while (!halted && cyc < 2000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    chk("R9 cycles to halt", 32'(cyc), 32'(4 * (n + 1)));
    chk("R3 R5 acc", 32'(acc), 32'(racc));
    chk("R7 halted", 32'(halted), 1);
    chk("R7 pc at halt", 32'(pc), 32'(3 * n));
    chk("R8 ifetch bytes", ifetch_bytes, 32'(3 * (n + 1)));
    chk("R8 R6 data bytes", data_bytes, 32'(2 * dops));
    begin
      int bad = 0;
      for (int i = 0; i < 512; i++) if (dmem[i] !== mref[i]) bad++;
      chk("R4 data memory", 32'(bad), 0);
    end
    pc_h = pc; if_h = ifetch_bytes;
    repeat (8) @(negedge clk);
    chk("R7 pc frozen", 32'(pc), 32'(pc_h));
    chk("R7 no fetch after halt", ifetch_bytes, if_h);
    chk("R7 no write after halt", 32'(post_halt_wr), 0);
    chk("R2 fetch addresses", 32'(fetch_err), 0);
    chk("R2 fetch count", 32'(fetch_exp), 32'(3 * (n + 1)));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) dmem[i] = 16'($urandom);
    dmem[16'h005] = 16'hFFFF; dmem[16'h106] = 16'h0001; dmem[16'h007] = 16'h8000;
    p_op[0] = 8'h01; p_ad[0] = 16'h0005;
    p_op[1] = 8'h03; p_ad[1] = 16'h0106;
    p_op[2] = 8'h03; p_ad[2] = 16'h0007;
    p_op[3] = 8'h02; p_ad[3] = 16'h0010;
    p_op[4] = 8'h7E; p_ad[4] = 16'h0005;
    p_op[5] = 8'h03; p_ad[5] = 16'h0007;
    p_op[6] = 8'h02; p_ad[6] = 16'h0011;
    p_op[7] = 8'h00; p_ad[7] = 16'h0106;
    p_op[8] = 8'h01; p_ad[8] = 16'h0010;
    run_prog(9);
    chk("R5 wrap stored", 32'(dmem[16'h011]), 0);
    chk("R3 final load", 32'(acc), 32'h8000);
    run_prog(0);
    for (int r = 0; r < 6; r++) begin
      int n = $urandom_range(5, 40);
      for (int i = 0; i < n; i++) begin
        int sel = $urandom_range(0, 9);
        p_op[i] = (sel < 3) ? 8'h01 : (sel < 6) ? 8'h03 : (sel < 8) ? 8'h02 :
                  8'($urandom_range(4, 254));
        p_ad[i] = mk_addr();
      end
      run_prog(n);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule